// File: doc/BRIEF.md
# Configuration Output Source Selector

This block drives a six-bit configuration code onto open-drain pins, picking it from one of five sources: four stored six-bit registers held elsewhere in the chip, or a six-bit set of external input pins. Two select pins normally decide the source. A command arriving from the bus side can take that decision away from the pins, and it keeps it until a release command or a reset.

A seventh, single-bit output carries the top bit of stored register 0 or stored register 1. It follows its source while select pin 0 is low and freezes while select pin 0 is high. Both outputs are registered on the system clock and are presented as pull-down enables: an enable of 1 pulls the line low (logic 0), and an enable of 0 releases it (logic 1).

The override strobe and its code are plain control inputs. They are sampled on every clock edge and need no handshake. There is no back-pressure anywhere in the block.

Top module: `cfg_out_selector`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, all seven pull-down enables read 0 (lines released), and no override is in force.
- R2: With no override in force, the select pins {sel_pin_i[1], sel_pin_i[0]} choose the source as follows: 2'b00 picks stored register 0, 2'b10 picks stored register 1, 2'b01 picks stored register 2, and 2'b11 picks the external input pins.
- R3: Each bit of cfg_od_en_o is the inverse of the selected source bit in the same position, so a source bit of 0 pulls its line low.
- R4: A strobe on ovr_valid_i with code 0 to NREG-1 selects the stored register of that index, and code NREG (4) selects the external pins. The choice holds regardless of the select pins until the next valid override code, release or reset.
- R5: A strobe with code NREG+1 (5) ends the override, and pin-based selection applies again from the same edge.
- R6: A strobe with any code above NREG+1 (6 or 7) has no effect: the source in force stays as it was.
- R7: Each output shows, after a clock edge, the result for the inputs sampled at that edge, including a strobe present at that edge. This is one edge of latency.
- R8: side_od_en_o is the inverse of a held bit. The held bit takes the new candidate at every edge where sel_pin_i[0] is 0 and keeps its value at every edge where sel_pin_i[0] is 1.
- R9: The side candidate is bit WIDTH-1 of a stored register. It is register 0 under an override with code 0 and register 1 under an override with code 1. In every other case it is register 1 if sel_pin_i[1] is 1 and register 0 otherwise.
- R10: With stored register 1 all zeros, no override and sel_pin_i[0] at 0, raising sel_pin_i[1] pulls all six configuration lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stored_regs_i | input | NREG*WIDTH | Stored registers, register n at bits [n*WIDTH +: WIDTH] |
| pin_in_i | input | WIDTH | External source pins |
| sel_pin_i | input | 2 | Source select pins |
| ovr_valid_i | input | 1 | Override command strobe, one cycle |
| ovr_code_i | input | CODE_W | Override command code |
| cfg_od_en_o | output | WIDTH | Pull-down enables of the configuration lines |
| side_od_en_o | output | 1 | Pull-down enable of the held side line |

## Verification
A corrupted override state shows up as a configuration code that belongs to the wrong source on the edge after the fault. It is seen as soon as the sources hold distinct values, so the sweeps keep every source pattern different. A wrong side hold state shows only when select pin 0 is high and the stored top bits change underneath it. The bench therefore changes the stored registers while holding, and compares the side line against a model on every edge.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

  typedef enum logic [1:0] {
    OVR_NONE  = 2'd0,
    OVR_TAKE  = 2'd1,
    OVR_DROP  = 2'd2
  } ovr_act_e;

  // Classify a strobed code against the number of stored registers.
  function automatic ovr_act_e classify(input logic valid, input int unsigned code,
                                        input int unsigned nreg);
    if (!valid)                return OVR_NONE;
    else if (code <= nreg)     return OVR_TAKE;
    else if (code == nreg + 1) return OVR_DROP;
    else                       return OVR_NONE;
  endfunction

endpackage

// File: rtl/cfgsel_ovr_ctrl.sv
module cfgsel_ovr_ctrl #(
  parameter int NREG   = 4,
  parameter int CODE_W = $clog2(NREG + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_q_o,
  output logic              eff_active_o,
  output logic [CODE_W-1:0] eff_code_o
);
  import cfgsel_pkg::*;

  ovr_act_e          act;
  logic              active_q;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    act = classify(valid_i, int'(code_i), NREG);
    unique case (act)
      OVR_TAKE: begin
        eff_active_o = 1'b1;
        eff_code_o   = code_i;
      end
      OVR_DROP: begin
        eff_active_o = 1'b0;
        eff_code_o   = code_q;
      end
      default: begin
        eff_active_o = active_q;
        eff_code_o   = code_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      code_q   <= '0;
    end else begin
      active_q <= eff_active_o;
      code_q   <= eff_code_o;
    end
  end

  assign active_q_o = active_q;

endmodule

// File: rtl/cfgsel_src_mux.sv
module cfgsel_src_mux #(
  parameter int WIDTH  = 6,
  parameter int NREG   = 4,
  parameter int CODE_W = $clog2(NREG + 2)
) (
  input  logic [NREG*WIDTH-1:0] regs_i,
  input  logic [WIDTH-1:0]      pins_i,
  input  logic [1:0]            sel_i,
  input  logic                  eff_active_i,
  input  logic [CODE_W-1:0]     eff_code_i,
  output logic [WIDTH-1:0]      data_o,
  output logic                  side_cand_o
);
  localparam int NSRC = NREG + 1;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0]  src [NSRC];
  logic [CODE_W-1:0] pin_idx;
  logic [CODE_W-1:0] idx;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign src[g] = regs_i[g*WIDTH +: WIDTH];
  end
  assign src[NREG] = pins_i;

  always_comb begin
    unique case (sel_i)
      2'b00:   pin_idx = CODE_W'(0);
      2'b10:   pin_idx = CODE_W'(1);
      2'b01:   pin_idx = CODE_W'(2);
      default: pin_idx = CODE_W'(NREG);
    endcase
  end

  assign idx = eff_active_i ? eff_code_i : pin_idx;

  always_comb begin
    data_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (idx == CODE_W'(k)) data_o = src[k];
    end
  end

  always_comb begin
    if (eff_active_i && eff_code_i == CODE_W'(0))      side_cand_o = src[0][MSB];
    else if (eff_active_i && eff_code_i == CODE_W'(1)) side_cand_o = src[1][MSB];
    else if (sel_i[1])                                 side_cand_o = src[1][MSB];
    else                                               side_cand_o = src[0][MSB];
  end

endmodule

// File: rtl/cfgsel_out_stage.sv
module cfgsel_out_stage #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_i,
  input  logic             side_cand_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] od_en_o,
  output logic             side_od_en_o
);
  logic [WIDTH-1:0] val_q;
  logic             side_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '1;
      side_q <= 1'b1;
    end else begin
      val_q <= data_i;
      if (!hold_i) side_q <= side_cand_i;
    end
  end

  assign od_en_o      = ~val_q;
  assign side_od_en_o = ~side_q;

endmodule

// File: rtl/cfg_out_selector.sv
module cfg_out_selector #(
  parameter int WIDTH  = 6,
  parameter int NREG   = 4,
  parameter int CODE_W = $clog2(NREG + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG*WIDTH-1:0] stored_regs_i,
  input  logic [WIDTH-1:0]      pin_in_i,
  input  logic [1:0]            sel_pin_i,
  input  logic                  ovr_valid_i,
  input  logic [CODE_W-1:0]     ovr_code_i,
  output logic [WIDTH-1:0]      cfg_od_en_o,
  output logic                  side_od_en_o
);
  logic              ovr_active;
  logic              eff_active;
  logic [CODE_W-1:0] eff_code;
  logic [WIDTH-1:0]  sel_data;
  logic              side_cand;

  cfgsel_ovr_ctrl #(.NREG(NREG), .CODE_W(CODE_W)) u_ovr (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (ovr_valid_i),
    .code_i       (ovr_code_i),
    .active_q_o   (ovr_active),
    .eff_active_o (eff_active),
    .eff_code_o   (eff_code)
  );

  cfgsel_src_mux #(.WIDTH(WIDTH), .NREG(NREG), .CODE_W(CODE_W)) u_mux (
    .regs_i       (stored_regs_i),
    .pins_i       (pin_in_i),
    .sel_i        (sel_pin_i),
    .eff_active_i (eff_active),
    .eff_code_i   (eff_code),
    .data_o       (sel_data),
    .side_cand_o  (side_cand)
  );

  cfgsel_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_i       (sel_data),
    .side_cand_i  (side_cand),
    .hold_i       (sel_pin_i[0]),
    .od_en_o      (cfg_od_en_o),
    .side_od_en_o (side_od_en_o)
  );

endmodule

// File: rtl/cfg_out_selector_chk.sv
module cfg_out_selector_chk #(
  parameter int WIDTH  = 6,
  parameter int NREG   = 4,
  parameter int CODE_W = $clog2(NREG + 2)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NREG*WIDTH-1:0] stored_regs_i,
  input logic [WIDTH-1:0]      pin_in_i,
  input logic [1:0]            sel_pin_i,
  input logic                  ovr_valid_i,
  input logic [CODE_W-1:0]     ovr_code_i,
  input logic [WIDTH-1:0]      cfg_od_en_o,
  input logic                  side_od_en_o,
  input logic                  ovr_active
);

  assert_side_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pin_i[0] |=> $stable(side_od_en_o));

  assert_pins_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_active && !ovr_valid_i && sel_pin_i == 2'b11)
      |=> cfg_od_en_o == ~$past(pin_in_i));

  assert_ovr_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && ovr_code_i == CODE_W'(NREG))
      |=> cfg_od_en_o == ~$past(pin_in_i));

  assert_ovr_reg0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && ovr_code_i == CODE_W'(0))
      |=> cfg_od_en_o == ~$past(stored_regs_i[WIDTH-1:0]));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && ovr_code_i == CODE_W'(NREG + 1)) |=> !ovr_active);

  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_i && ovr_code_i > CODE_W'(NREG + 1)) |=> $stable(ovr_active));

endmodule

bind cfg_out_selector cfg_out_selector_chk #(
  .WIDTH(WIDTH), .NREG(NREG), .CODE_W(CODE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stored_regs_i (stored_regs_i),
  .pin_in_i      (pin_in_i),
  .sel_pin_i     (sel_pin_i),
  .ovr_valid_i   (ovr_valid_i),
  .ovr_code_i    (ovr_code_i),
  .cfg_od_en_o   (cfg_od_en_o),
  .side_od_en_o  (side_od_en_o),
  .ovr_active    (ovr_active)
);

// File: tb/cfg_out_selector_tb.sv
module cfg_out_selector_tb_top;
  localparam int WIDTH   = 6;
  localparam int NREG    = 4;
  localparam int CODE_W  = 3;
  localparam int CLK_PER = 10;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NREG*WIDTH-1:0] regs = '0;
  logic [WIDTH-1:0]      pins = '0;
  logic [1:0]            sel = 2'b00;
  logic                  ovr_valid = 1'b0;
  logic [CODE_W-1:0]     ovr_code = '0;
  logic [WIDTH-1:0]      cfg_en;
  logic                  side_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_act = 0;
  int unsigned m_code = 0;
  bit          m_side = 1;

  always #(CLK_PER/2) clk = ~clk;

  cfg_out_selector #(.WIDTH(WIDTH), .NREG(NREG), .CODE_W(CODE_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .stored_regs_i (regs),
    .pin_in_i      (pins),
    .sel_pin_i     (sel),
    .ovr_valid_i   (ovr_valid),
    .ovr_code_i    (ovr_code),
    .cfg_od_en_o   (cfg_en),
    .side_od_en_o  (side_en)
  );

  function automatic logic [WIDTH-1:0] reg_of(int n);
    return regs[n*WIDTH +: WIDTH];
  endfunction

  function automatic logic [WIDTH-1:0] expect_val();
    int n;
    if (m_act) n = int'(m_code);
    else case (sel)
      2'b00: n = 0;
      2'b10: n = 1;
      2'b01: n = 2;
      default: n = NREG;
    endcase
    return (n == NREG) ? pins : reg_of(n);
  endfunction

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One edge: update the bench model from the inputs seen at the edge, then compare.
  task automatic tick(string tag);
    bit cand;
    @(posedge clk);
    if (ovr_valid) begin
      if (int'(ovr_code) <= NREG) begin m_act = 1; m_code = ovr_code; end
      else if (int'(ovr_code) == NREG + 1) m_act = 0;
    end
    if (m_act && m_code == 0)      cand = reg_of(0)[WIDTH-1];
    else if (m_act && m_code == 1) cand = reg_of(1)[WIDTH-1];
    else if (sel[1])               cand = reg_of(1)[WIDTH-1];
    else                           cand = reg_of(0)[WIDTH-1];
    if (!sel[0]) m_side = cand;
    #1;
    check({tag, " cfg"}, cfg_en, ~expect_val());
    check({tag, " side R9"}, {{(WIDTH-1){1'b0}}, side_en}, {{(WIDTH-1){1'b0}}, ~m_side});
  endtask

  task automatic strobe(int code, string tag);
    ovr_valid = 1'b1;
    ovr_code = CODE_W'(code);
    tick(tag);
    ovr_valid = 1'b0;
  endtask

  function automatic void load_pattern(int p);
    for (int n = 0; n < NREG; n++)
      regs[n*WIDTH +: WIDTH] = WIDTH'((p * 7 + n * 13 + 5) ^ (n << 2));
    pins = WIDTH'(p * 11 + 3);
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset cfg", cfg_en, '0);
    check("R1 reset side", {{(WIDTH-1){1'b0}}, side_en}, '0);
    load_pattern(1);
    sel = 2'b11;
    #1;
    check("R1 reset holds with inputs moving", cfg_en, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 before first edge", cfg_en, '0);

    // R2, R3, R7: pin-based selection sweep
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 24; p++) begin
        sel = 2'(s);
        load_pattern(p + s * 31);
        tick("R2 R3 R7 pin select");
      end
    end

    // R4, R6, R5: every code under every select setting
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 4; s++) begin
        sel = 2'(s);
        load_pattern(c * 5 + s);
        strobe(c, "R4 R5 R6 strobe");
        load_pattern(c * 5 + s + 40);
        tick("R4 R6 persist");
        sel = 2'(s ^ 3);
        tick("R4 pins ignored under override");
      end
      strobe(NREG + 1, "R5 release");
    end

    // R8: hold while sel_pin_i[0] is 1 and registers change
    sel = 2'b00;
    load_pattern(3);
    regs[WIDTH-1] = 1'b1;
    tick("R8 transparent");
    sel = 2'b01;
    for (int p = 0; p < 8; p++) begin
      load_pattern(p);
      regs[WIDTH-1] = p[0];
      tick("R8 hold");
    end
    sel = 2'b00;
    regs[WIDTH-1] = 1'b0;
    tick("R8 transparent again");

    // R9: side source under overrides 0 and 1
    for (int c = 0; c < 2; c++) begin
      sel = 2'b00;
      strobe(c, "R9 override source");
      for (int p = 0; p < 4; p++) begin
        regs[WIDTH-1] = p[0];
        regs[2*WIDTH-1] = p[1];
        sel = 2'(p[1:0] & 2'b10);
        tick("R9 side candidate");
      end
    end
    strobe(NREG + 1, "R5 release again");

    // R10: register 1 zero, select pin 1 forces all lines low
    load_pattern(9);
    regs[WIDTH +: WIDTH] = '0;
    sel = 2'b00;
    tick("R10 baseline");
    sel = 2'b10;
    tick("R10 forced");
    check("R10 all lines pulled", cfg_en, '1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule